// File: doc/BRIEF.md
# 2B+D Field to 2B1Q Quat Mapper

The block accepts one 18-bit field made of two 8-bit bearer octets and a 2-bit signalling pair, and emits it as nine 2B1Q quats. Each emitted quat is given both as a (sign, magnitude) bit pair and as a signed four-level symbol value. One quat leaves on every cycle in which the quat strobe `en_i` is high. A flag marks the ninth quat of each field.

A field is captured on `load_i`. The mapper accepts a new field in the same cycle in which the last quat of the previous field leaves. A line frame of twelve fields can therefore stream without any idle quat between fields. A load that arrives while a field is still being emitted, other than in that last-quat cycle, is dropped and reported with a one-cycle error pulse. Scrambling, sync word insertion and line driving are handled elsewhere.

Top module: `bd_quat_mapper`

## Requirements
- R1: After reset `quat_vld_o`, `last_o` and `load_err_o` are 0. With no load, they stay 0 whatever `en_i` does.
- R2: Each accepted field yields exactly 9 cycles with `quat_vld_o`=1. `last_o` is 1 only on the ninth of them, and after it `quat_vld_o` stays 0 until the next load.
- R3: Quats 1 to 4 carry `b1_i` two bits at a time, starting from bit 7 (bit 7 is the first received bit): quat 1 = {b1_i[7], b1_i[6]} and quat 4 = {b1_i[1], b1_i[0]}.
- R4: Quats 5 to 8 carry `b2_i` in the same order: quat 5 = {b2_i[7], b2_i[6]} and quat 8 = {b2_i[1], b2_i[0]}.
- R5: Quat 9 is {d_i[1], d_i[0]}, where `d_i[1]` is the first received signalling bit.
- R6: In every quat the first bit of the pair is output on `sign_o` and the second on `mag_o`.
- R7: `sym_o` is a 3-bit two's-complement value encoding (sign, mag): 10 → +3, 11 → +1, 01 → -1, 00 → -3.
- R8: While `en_i`=0 the mapper outputs no valid quat and does not advance. The next enabled cycle emits the quat that was pending.
- R9: A load in the cycle where `last_o`=1 is accepted. The first quat of the new field follows on the next enabled cycle, and twelve fields stream with no gap.
- R10: A load while a field is pending, in any cycle other than the last-quat cycle, is ignored: the ongoing quat sequence is unchanged. `load_err_o` pulses high for one cycle, in the cycle after that load.
- R11: The load cycle of an idle mapper emits no valid quat. The first quat of the field appears on the first enabled cycle after the load cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Quat strobe; one quat leaves per high cycle |
| load_i | input | 1 | Capture field from `b1_i`, `b2_i`, `d_i` |
| b1_i | input | 8 | First bearer octet, bit 7 received first |
| b2_i | input | 8 | Second bearer octet, bit 7 received first |
| d_i | input | 2 | Signalling pair, bit 1 received first |
| quat_vld_o | output | 1 | Current quat outputs are valid |
| sign_o | output | 1 | Sign bit of current quat |
| mag_o | output | 1 | Magnitude bit of current quat |
| sym_o | output | 3 | Signed symbol value (+3, +1, -1, -3) |
| last_o | output | 1 | Current quat is the ninth of its field |
| load_err_o | output | 1 | Pulse: previous-cycle load was dropped |

## Verification
A corrupt quat counter shows up at the ports within one field. `last_o` lands on the wrong valid cycle, or the number of valid cycles per field differs from nine. Both are visible before the next load can be accepted. A wrong shift-register state shows up as a misplaced or swapped pair on `sign_o`/`mag_o` on the very quat it affects. A wrong busy state shows up in two ways: a dropped back-to-back field, or a spurious or missing `load_err_o` pulse one cycle after the offending load.

// File: rtl/qmap_pkg.sv
`timescale 1ns/1ps
package qmap_pkg;
  typedef struct packed {
    logic sign;
    logic mag;
  } quat_t;

  typedef logic signed [2:0] sym_t;

  localparam sym_t SYM_P3 = 3'sd3;
  localparam sym_t SYM_P1 = 3'sd1;
  localparam sym_t SYM_M1 = -3'sd1;
  localparam sym_t SYM_M3 = -3'sd3;
endpackage

// File: rtl/qmap_field_pack.sv
`timescale 1ns/1ps
// Interleaves B1, B2, D into transmit order, first quat in the top two bits.
module qmap_field_pack #(
  parameter int unsigned B_W = 8,
  parameter int unsigned D_W = 2,
  localparam int unsigned FIELD_W = 2*B_W + D_W
) (
  input  logic [B_W-1:0]     b1_i,
  input  logic [B_W-1:0]     b2_i,
  input  logic [D_W-1:0]     d_i,
  output logic [FIELD_W-1:0] field_o
);
  localparam int unsigned BQ = B_W/2;
  localparam int unsigned DQ = D_W/2;

  for (genvar g = 0; g < BQ; g++) begin : g_b1
    assign field_o[FIELD_W-1-2*g -: 2] = b1_i[B_W-1-2*g -: 2];
  end
  for (genvar g = 0; g < BQ; g++) begin : g_b2
    assign field_o[FIELD_W-1-2*(BQ+g) -: 2] = b2_i[B_W-1-2*g -: 2];
  end
  for (genvar g = 0; g < DQ; g++) begin : g_d
    assign field_o[D_W-1-2*g -: 2] = d_i[D_W-1-2*g -: 2];
  end
endmodule

// File: rtl/qmap_seq.sv
`timescale 1ns/1ps
module qmap_seq
  import qmap_pkg::*;
#(
  parameter int unsigned FIELD_W = 18,
  localparam int unsigned NQ    = FIELD_W/2,
  localparam int unsigned CNT_W = $clog2(NQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               load_i,
  input  logic [FIELD_W-1:0] field_i,
  output quat_t              quat_o,
  output logic               vld_o,
  output logic               last_o,
  output logic               err_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NQ-1);

  logic               busy_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FIELD_W-1:0] sr_q;
  logic               err_q;
  logic               adv, at_last, accept;

  assign adv     = busy_q & en_i;
  assign at_last = (cnt_q == LAST_IDX);
  // a field may enter on the cycle its predecessor's last quat leaves
  assign accept  = load_i & (~busy_q | (adv & at_last));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sr_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= load_i & ~accept;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        sr_q   <= field_i;
      end else if (adv) begin
        sr_q <= {sr_q[FIELD_W-3:0], 2'b00};
        if (at_last) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign quat_o.sign = sr_q[FIELD_W-1];
  assign quat_o.mag  = sr_q[FIELD_W-2];
  assign vld_o       = adv;
  assign last_o      = adv & at_last;
  assign err_o       = err_q;
endmodule

// File: rtl/qmap_sym_enc.sv
`timescale 1ns/1ps
module qmap_sym_enc
  import qmap_pkg::*;
(
  input  quat_t quat_i,
  output sym_t  sym_o
);
  always_comb begin
    unique case ({quat_i.sign, quat_i.mag})
      2'b10:   sym_o = SYM_P3;
      2'b11:   sym_o = SYM_P1;
      2'b01:   sym_o = SYM_M1;
      default: sym_o = SYM_M3;
    endcase
  end
endmodule

// File: rtl/bd_quat_mapper.sv
`timescale 1ns/1ps
module bd_quat_mapper
  import qmap_pkg::*;
#(
  parameter int unsigned B_W = 8,
  parameter int unsigned D_W = 2,
  localparam int unsigned FIELD_W = 2*B_W + D_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           load_i,
  input  logic [B_W-1:0] b1_i,
  input  logic [B_W-1:0] b2_i,
  input  logic [D_W-1:0] d_i,
  output logic           quat_vld_o,
  output logic           sign_o,
  output logic           mag_o,
  output logic [2:0]     sym_o,
  output logic           last_o,
  output logic           load_err_o
);
  logic [FIELD_W-1:0] field;
  quat_t              quat;
  sym_t               sym;

  qmap_field_pack #(.B_W(B_W), .D_W(D_W)) u_pack (
    .b1_i    (b1_i),
    .b2_i    (b2_i),
    .d_i     (d_i),
    .field_o (field)
  );

  qmap_seq #(.FIELD_W(FIELD_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .load_i  (load_i),
    .field_i (field),
    .quat_o  (quat),
    .vld_o   (quat_vld_o),
    .last_o  (last_o),
    .err_o   (load_err_o)
  );

  qmap_sym_enc u_enc (
    .quat_i (quat),
    .sym_o  (sym)
  );

  assign sign_o = quat.sign;
  assign mag_o  = quat.mag;
  assign sym_o  = sym;
endmodule

// File: rtl/bd_quat_mapper_chk.sv
`timescale 1ns/1ps
module bd_quat_mapper_chk #(
  parameter int unsigned NQ = 9,
  localparam int unsigned CW = $clog2(NQ)
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       load_i,
  input logic       quat_vld_o,
  input logic       sign_o,
  input logic       mag_o,
  input logic [2:0] sym_o,
  input logic       last_o,
  input logic       load_err_o
);
  logic [CW-1:0] vcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         vcnt_q <= '0;
    else if (last_o)     vcnt_q <= '0;
    else if (quat_vld_o) vcnt_q <= vcnt_q + 1'b1;
  end

  AST_LAST_IS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> quat_vld_o); // R2
  AST_LAST_ON_NINTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> (vcnt_q == CW'(NQ-1))); // R2
  AST_NINTH_IS_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quat_vld_o && vcnt_q == CW'(NQ-1)) |-> last_o); // R2
  AST_NO_VLD_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !quat_vld_o); // R8
  AST_SYM_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quat_vld_o |-> (sym_o == ({sign_o, mag_o} == 2'b10 ? 3'b011 :
                              {sign_o, mag_o} == 2'b11 ? 3'b001 :
                              {sign_o, mag_o} == 2'b01 ? 3'b111 : 3'b101))); // R7
  AST_ERR_FROM_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_err_o |-> $past(load_i)); // R10
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_err_o |=> !load_err_o || $past(load_i)); // R10
endmodule

bind bd_quat_mapper bd_quat_mapper_chk #(.NQ(FIELD_W/2)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .load_i     (load_i),
  .quat_vld_o (quat_vld_o),
  .sign_o     (sign_o),
  .mag_o      (mag_o),
  .sym_o      (sym_o),
  .last_o     (last_o),
  .load_err_o (load_err_o)
);

// File: tb/bd_quat_mapper_tb.sv
`timescale 1ns/1ps
module bd_quat_mapper_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0, load_i = 1'b0;
  logic [7:0] b1_i = '0, b2_i = '0;
  logic [1:0] d_i = '0;
  logic       quat_vld_o, sign_o, mag_o, last_o, load_err_o;
  logic [2:0] sym_o;

  int n_run = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  bd_quat_mapper u_dut (.*);

  function automatic int exp_sym(input logic s, input logic m);
    case ({s, m})
      2'b10:   return 3;
      2'b11:   return 1;
      2'b01:   return -1;
      default: return -3;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic en, input logic ld, input logic [7:0] b1,
                       input logic [7:0] b2, input logic [1:0] d);
    @(negedge clk_i);
    en_i = en; load_i = ld; b1_i = b1; b2_i = b2; d_i = d;
    #1;
  endtask

  // expects quat k (0-based) of field vec on the ports now
  task automatic exp_quat(input logic [17:0] vec, input int k);
    string req;
    logic  s, m;
    req = (k < 4) ? "R3" : (k < 8) ? "R4" : "R5";
    s = vec[17-2*k];
    m = vec[16-2*k];
    chk(quat_vld_o === 1'b1, "R2", $sformatf("valid q%0d", k+1), int'(quat_vld_o), 1);
    chk(sign_o === s, req, $sformatf("R6 sign q%0d", k+1), int'(sign_o), int'(s));
    chk(mag_o === m, req, $sformatf("R6 mag q%0d", k+1), int'(mag_o), int'(m));
    chk(int'($signed(sym_o)) == exp_sym(s, m), "R7", $sformatf("sym q%0d", k+1),
        int'($signed(sym_o)), exp_sym(s, m));
    chk(last_o === (k == 8), "R2", $sformatf("last q%0d", k+1), int'(last_o), int'(k == 8));
  endtask

  task automatic t_reset();
    drive(1'b1, 1'b0, 8'hFF, 8'hFF, 2'b11);
    chk(quat_vld_o === 1'b0, "R1", "valid after reset", int'(quat_vld_o), 0);
    chk(last_o === 1'b0, "R1", "last after reset", int'(last_o), 0);
    chk(load_err_o === 1'b0, "R1", "err after reset", int'(load_err_o), 0);
  endtask

  task automatic t_single(input logic [7:0] b1, input logic [7:0] b2, input logic [1:0] d);
    logic [17:0] v;
    v = {b1, b2, d};
    drive(1'b1, 1'b1, b1, b2, d);
    chk(quat_vld_o === 1'b0, "R11", "no valid in load cycle", int'(quat_vld_o), 0);
    for (int k = 0; k < 9; k++) begin
      drive(1'b1, 1'b0, ~b1, ~b2, ~d);
      exp_quat(v, k);
    end
    drive(1'b1, 1'b0, 8'h00, 8'h00, 2'b00);
    chk(quat_vld_o === 1'b0, "R2", "idle after ninth quat", int'(quat_vld_o), 0);
    chk(load_err_o === 1'b0, "R10", "no err for clean load", int'(load_err_o), 0);
  endtask

  task automatic t_stall(input logic [7:0] b1, input logic [7:0] b2, input logic [1:0] d);
    logic [17:0] v;
    v = {b1, b2, d};
    drive(1'b0, 1'b1, b1, b2, d);
    for (int k = 0; k < 9; k++) begin
      drive(1'b0, 1'b0, 8'h00, 8'h00, 2'b00);
      chk(quat_vld_o === 1'b0, "R8", "no valid while stalled", int'(quat_vld_o), 0);
      chk(last_o === 1'b0, "R8", "no last while stalled", int'(last_o), 0);
      drive(1'b1, 1'b0, 8'h00, 8'h00, 2'b00);
      exp_quat(v, k);
    end
    drive(1'b1, 1'b0, 8'h00, 8'h00, 2'b00);
    chk(quat_vld_o === 1'b0, "R2", "idle after stalled field", int'(quat_vld_o), 0);
  endtask

  task automatic t_b2b();
    logic [17:0] v [12];
    for (int f = 0; f < 12; f++) v[f] = 18'((f * 18'h0B3A7) ^ (f << 9) ^ 18'h2C5D1);
    drive(1'b0, 1'b1, v[0][17:10], v[0][9:2], v[0][1:0]);
    for (int f = 0; f < 12; f++) begin
      for (int k = 0; k < 9; k++) begin
        if (k == 8 && f < 11)
          drive(1'b1, 1'b1, v[f+1][17:10], v[f+1][9:2], v[f+1][1:0]);
        else
          drive(1'b1, 1'b0, 8'h00, 8'h00, 2'b00);
        if (k == 0 && f > 0)
          chk(load_err_o === 1'b0, "R9", "last-cycle load not flagged", int'(load_err_o), 0);
        if (f > 0 && k == 0)
          chk(quat_vld_o === 1'b1, "R9", $sformatf("no gap before field %0d", f),
              int'(quat_vld_o), 1);
        exp_quat(v[f], k);
      end
    end
    drive(1'b1, 1'b0, 8'h00, 8'h00, 2'b00);
    chk(quat_vld_o === 1'b0, "R9", "idle after 12 fields", int'(quat_vld_o), 0);
  endtask

  task automatic t_busy_load();
    logic [17:0] va, vb;
    va = {8'hC6, 8'h39, 2'b01};
    vb = {8'h0F, 8'hF0, 2'b10};
    drive(1'b1, 1'b1, va[17:10], va[9:2], va[1:0]);
    for (int k = 0; k < 9; k++) begin
      if (k == 3)
        drive(1'b1, 1'b1, vb[17:10], vb[9:2], vb[1:0]);
      else if (k == 6)
        drive(1'b0, 1'b1, vb[17:10], vb[9:2], vb[1:0]);
      else
        drive(1'b1, 1'b0, 8'h00, 8'h00, 2'b00);
      if (k == 7) begin
        chk(load_err_o === 1'b1, "R10", "err after stalled busy load", int'(load_err_o), 1);
        chk(quat_vld_o === 1'b1, "R10", "sequence continues", int'(quat_vld_o), 1);
      end
      if (k == 4)
        chk(load_err_o === 1'b1, "R10", "err after busy load", int'(load_err_o), 1);
      if (k == 5)
        chk(load_err_o === 1'b0, "R10", "err is one cycle", int'(load_err_o), 0);
      if (k == 6)
        chk(quat_vld_o === 1'b0, "R8", "stall cycle no valid", int'(quat_vld_o), 0);
      else
        exp_quat(va, (k > 6) ? k - 1 : k);
    end
    // the ninth quat slipped one cycle due to the stall
    drive(1'b1, 1'b0, 8'h00, 8'h00, 2'b00);
    exp_quat(va, 8);
    drive(1'b1, 1'b0, 8'h00, 8'h00, 2'b00);
    chk(quat_vld_o === 1'b0, "R10", "dropped field never emitted", int'(quat_vld_o), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_single(8'hA5, 8'h3C, 2'b10);
    t_single(8'h00, 8'hFF, 2'b01);
    t_single(8'hFF, 8'h00, 2'b11);
    t_single(8'h1B, 8'hE4, 2'b00);
    t_stall(8'h96, 8'h69, 2'b10);
    t_b2b();
    t_busy_load();
    t_reset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule